// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the device side of a three-wire serial nonvolatile memory. It is modelled in synthesizable logic. A host selects it with a chip-select line and clocks instruction frames into a data input with a shift clock. The block answers on a data output that it drives only while selected.

The storage is a 1 Kbit register array. An organization input views the array either as 128 bytes or as 64 sixteen-bit words. Each frame opens with a start bit and a two-bit opcode. The opcodes are read, write, erase, and a special group. In the special group, the top address bits choose one of four commands: enable programming, disable programming, erase everything, or write one value everywhere.

All programming is gated by a write-enable latch. Each program operation starts a self-timed cycle, which a counter models. While that cycle runs, the block ignores new instructions and reports ready or busy on the data output whenever chip select is high.

The block samples its pins on a system clock `clk`. The shift clock must stay in each level for at least one `clk` period.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A frame begins at the first SK rising edge that samples DI = 1 while CS is high and the block is idle. Zeros clocked in before that start bit are ignored.
- R2: Opcode 10 is a read. On the SK rise that takes the last address bit, DO drives a dummy 0 with output enable high. Each following SK rise then presents the next data bit, most significant bit first.
- R3: With org high, the block uses 16-bit words and 6-bit addresses. With org low, it uses 8-bit words and 7-bit addresses. Word w in 16-bit mode is made of byte 2w (upper half) and byte 2w+1 (lower half) of the byte view.
- R4: Opcode 01 (write) takes an address and then a full word, most significant bit first. When chip select falls after the last data bit, the word is stored. No erase is needed beforehand.
- R5: Opcode 11 (erase) sets the addressed word to all ones.
- R6: In opcode 00, top address bits 10 erase the whole array to all ones. Top address bits 01 take one data word and write it to every word of the array.
- R7: In opcode 00, top address bits 11 set the write-enable latch and top address bits 00 clear it. While the latch is clear, write, erase, erase-all and write-all change nothing and start no program cycle. Reset clears the latch.
- R8: A program cycle begins on the first clk edge at which CS is sampled low after a complete programming frame. It lasts PROG_CYCLES clk cycles. While CS is high and the block is idle after that start, DO shows 0 while busy and 1 once the cycle has ended.
- R9: The output enable is low whenever CS is low. With CS high, it is high only during read output or status reporting.
- R10: Dropping CS before a frame is complete abandons the frame. Memory is unchanged and no program cycle starts.
- R11: While a program cycle is running, SK edges are not decoded, so a whole frame sent during that time has no effect.
- R12: After reset, the output enable stays low while CS is high and no frame has been sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock |
| di | input | 1 | Serial data in |
| org | input | 1 | Organization select: 1 = 16-bit words, 0 = 8-bit words |
| do_o | output | 1 | Serial data / status out |
| do_oe | output | 1 | Output enable for do_o (low means high impedance) |

## Verification
An SK rise is seen at the first `clk` edge where `sk` is high after being low, and every frame effect lands in the register update at that same edge. The read bits, dummy bit and enable-latch changes are therefore visible one `clk` edge after the rise. The bench holds each SK level for one full clock and samples DO on the falling `clk` edge that follows the high phase.

A program cycle starts at the first edge that samples CS low. The bench never checks status sooner than two clocks after raising CS again. It checks "busy" well inside the PROG_CYCLES window and "ready" only after PROG_CYCLES plus margin, so that no check sits on a cycle boundary.

Stored contents are checked only through later read frames. These are compared against a byte-level model that is updated only when the model's own enable latch is set.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_RD,
    ST_DONE
  } frame_st_t;

  typedef enum logic [1:0] {
    PK_WORD,
    PK_ERASE,
    PK_FILL,
    PK_CLEAR
  } prog_kind_t;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  localparam logic [1:0] OPC_SPEC  = 2'b00;

  localparam logic [1:0] SUB_EN    = 2'b11;
  localparam logic [1:0] SUB_DIS   = 2'b00;
  localparam logic [1:0] SUB_CLEAR = 2'b10;
  localparam logic [1:0] SUB_FILL  = 2'b01;

endpackage

// File: rtl/tw_sk_edge.sv
module tw_sk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sk,
  output logic rise
);

  logic sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk;
  end

  assign rise = sk & ~sk_q;

endmodule

// File: rtl/tw_prog_timer.sv
module tw_prog_timer #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start)            cnt_n = CW'(CYCLES);
    else if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/tw_array.sv
module tw_array #(
  parameter int BYTES = 128
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic                       fill,
  input  logic                       wide,
  input  logic [$clog2(BYTES)-1:0]   waddr,
  input  logic [15:0]                wdata,
  input  logic [$clog2(BYTES)-1:0]   raddr,
  output logic [15:0]                rdata
);

  localparam int AW = $clog2(BYTES);

  logic [7:0] mem [BYTES];
  logic [AW-1:0] w_hi, w_lo, r_hi, r_lo;

  assign w_hi = {waddr[AW-2:0], 1'b0};
  assign w_lo = {waddr[AW-2:0], 1'b1};
  assign r_hi = {raddr[AW-2:0], 1'b0};
  assign r_lo = {raddr[AW-2:0], 1'b1};

  always_ff @(posedge clk) begin
    if (we) begin
      if (fill) begin
        for (int i = 0; i < BYTES; i++) begin
          if (wide) mem[i] <= ((i % 2) == 1) ? wdata[7:0] : wdata[15:8];
          else      mem[i] <= wdata[7:0];
        end
      end else if (wide) begin
        mem[w_hi] <= wdata[15:8];
        mem[w_lo] <= wdata[7:0];
      end else begin
        mem[waddr] <= wdata[7:0];
      end
    end
  end

  assign rdata = wide ? {mem[r_hi], mem[r_lo]} : {8'h00, mem[raddr]};

endmodule

// File: rtl/tw_frame_ctrl.sv
module tw_frame_ctrl
  import tw_eeprom_pkg::*;
#(
  parameter int AW   = 7,
  parameter int DMAX = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            di,
  input  logic            org,
  input  logic            sk_rise,
  input  logic            busy,
  input  logic [15:0]     rd_data,
  output logic [AW-1:0]   rd_addr,
  output logic            start_prog,
  output logic            prog_fill,
  output logic [AW-1:0]   prog_addr,
  output logic [15:0]     prog_data,
  output logic            wel,
  output logic            rd_active,
  output logic            show_stat,
  output logic            do_bit
);

  localparam int CW = $clog2(DMAX + 1);

  frame_st_t     st_q, st_n;
  prog_kind_t    kind_q, kind_n;
  logic [1:0]    op_q, op_n;
  logic [CW-1:0] bcnt_q, bcnt_n;
  logic [AW-1:0] asr_q, asr_n, wa_q, wa_n;
  logic [15:0]   dsr_q, dsr_n, out_q, out_n;
  logic          wel_q, wel_n, pend_q, pend_n, stat_q, stat_n, dob_q, dob_n;

  logic [AW-1:0] addr_full, a_eff;
  logic [1:0]    sub;
  logic [CW-1:0] last_a, last_d, dw;
  logic          step;

  assign addr_full = {asr_q[AW-2:0], di};
  assign a_eff     = org ? {1'b0, addr_full[AW-2:0]} : addr_full;
  assign sub       = org ? addr_full[AW-2:AW-3] : addr_full[AW-1:AW-2];
  assign last_a    = org ? CW'(AW - 2) : CW'(AW - 1);
  assign dw        = org ? CW'(DMAX) : CW'(DMAX / 2);
  assign last_d    = dw - 1'b1;
  assign step      = sk_rise & cs & ~busy;

  always_comb begin
    st_n = st_q;  kind_n = kind_q; op_n = op_q;   bcnt_n = bcnt_q;
    asr_n = asr_q; wa_n = wa_q;    dsr_n = dsr_q; out_n = out_q;
    wel_n = wel_q; pend_n = pend_q; stat_n = stat_q; dob_n = dob_q;
    start_prog = 1'b0;
    if (!cs) begin
      st_n   = ST_IDLE;
      pend_n = 1'b0;
      start_prog = (st_q == ST_DONE) && pend_q;
    end else if (step) begin
      case (st_q)
        ST_IDLE: if (di) begin
          st_n = ST_OPC; bcnt_n = '0; stat_n = 1'b0;
        end
        ST_OPC: begin
          op_n = {op_q[0], di};
          if (bcnt_q == CW'(1)) begin st_n = ST_ADDR; bcnt_n = '0; end
          else bcnt_n = bcnt_q + 1'b1;
        end
        ST_ADDR: begin
          asr_n  = addr_full;
          bcnt_n = bcnt_q + 1'b1;
          if (bcnt_q == last_a) begin
            bcnt_n = '0;
            wa_n   = a_eff;
            case (op_q)
              OPC_READ:  begin st_n = ST_RD; out_n = rd_data; dob_n = 1'b0; end
              OPC_WRITE: begin st_n = ST_DATA; kind_n = PK_WORD; end
              OPC_ERASE: begin st_n = ST_DONE; kind_n = PK_ERASE; pend_n = wel_q; end
              default: begin
                case (sub)
                  SUB_EN:    begin st_n = ST_DONE; wel_n = 1'b1; end
                  SUB_DIS:   begin st_n = ST_DONE; wel_n = 1'b0; end
                  SUB_CLEAR: begin st_n = ST_DONE; kind_n = PK_CLEAR; pend_n = wel_q; end
                  default:   begin st_n = ST_DATA; kind_n = PK_FILL; end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          dsr_n = {dsr_q[14:0], di};
          if (bcnt_q == last_d) begin st_n = ST_DONE; pend_n = wel_q; end
          else bcnt_n = bcnt_q + 1'b1;
        end
        ST_RD: begin
          if (bcnt_q == dw) begin
            st_n = ST_DONE; dob_n = 1'b0;
          end else begin
            dob_n  = org ? out_q[15] : out_q[7];
            out_n  = {out_q[14:0], 1'b0};
            bcnt_n = bcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (start_prog) stat_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; kind_q <= PK_WORD; op_q <= '0;  bcnt_q <= '0;
      asr_q <= '0;     wa_q <= '0;        dsr_q <= '0; out_q <= '0;
      wel_q <= 1'b0;   pend_q <= 1'b0;    stat_q <= 1'b0; dob_q <= 1'b0;
    end else begin
      st_q <= st_n;    kind_q <= kind_n;  op_q <= op_n;   bcnt_q <= bcnt_n;
      asr_q <= asr_n;  wa_q <= wa_n;      dsr_q <= dsr_n; out_q <= out_n;
      wel_q <= wel_n;  pend_q <= pend_n;  stat_q <= stat_n; dob_q <= dob_n;
    end
  end

  assign rd_addr   = a_eff;
  assign prog_addr = wa_q;
  assign prog_fill = (kind_q == PK_FILL) || (kind_q == PK_CLEAR);
  assign prog_data = ((kind_q == PK_ERASE) || (kind_q == PK_CLEAR)) ? 16'hFFFF :
                     (org ? dsr_q : {8'h00, dsr_q[7:0]});
  assign wel       = wel_q;
  assign rd_active = (st_q == ST_RD);
  assign show_stat = stat_q && (st_q == ST_IDLE);
  assign do_bit    = dob_q;

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave #(
  parameter int ARRAY_BITS  = 1024,
  parameter int PROG_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic do_o,
  output logic do_oe
);

  localparam int BYTES = ARRAY_BITS / 8;
  localparam int AW    = $clog2(BYTES);
  localparam int DMAX  = 16;

  logic          sk_rise, prog_busy, start_prog, prog_fill;
  logic          wel, rd_active, show_stat, do_bit;
  logic [AW-1:0] rd_addr, prog_addr;
  logic [15:0]   rd_data, prog_data;

  tw_sk_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sk(sk), .rise(sk_rise)
  );

  tw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_prog), .busy(prog_busy)
  );

  tw_array #(.BYTES(BYTES)) u_array (
    .clk(clk), .we(start_prog), .fill(prog_fill), .wide(org),
    .waddr(prog_addr), .wdata(prog_data), .raddr(rd_addr), .rdata(rd_data)
  );

  tw_frame_ctrl #(.AW(AW), .DMAX(DMAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .org(org),
    .sk_rise(sk_rise), .busy(prog_busy), .rd_data(rd_data), .rd_addr(rd_addr),
    .start_prog(start_prog), .prog_fill(prog_fill), .prog_addr(prog_addr),
    .prog_data(prog_data), .wel(wel), .rd_active(rd_active),
    .show_stat(show_stat), .do_bit(do_bit)
  );

  assign do_oe = cs & (rd_active | show_stat);
  assign do_o  = show_stat ? ~prog_busy : do_bit;

endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic do_oe,
  input logic do_o,
  input logic busy,
  input logic wel,
  input logic start
);

  // R9
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !do_oe);

  // R7
  prog_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel);

  // R8
  busy_after_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cs));

  // R8
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  // R8
  status_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && do_oe) |-> !do_o);

  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

bind tw_eeprom_slave tw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .do_oe(do_oe), .do_o(do_o),
  .busy(prog_busy), .wel(wel), .start(start_prog)
);

// File: tb/tw_eeprom_slave_test.sv
module tw_eeprom_slave_test;

  localparam int PROG = 100;

  logic clk, rst_n, cs, sk, di, org;
  logic do_o, do_oe;
  int   runs, fails;
  logic [7:0] model [128];
  logic wel_m;

  tw_eeprom_slave #(.ARRAY_BITS(1024), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .do_o(do_o), .do_oe(do_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic o, input logic [6:0] a);
    if (o) return {model[{a[5:0], 1'b0}], model[{a[5:0], 1'b1}]};
    return {8'h00, model[a]};
  endfunction

  task automatic model_put(input logic o, input logic [6:0] a, input logic [15:0] d);
    if (o) begin
      model[{a[5:0], 1'b0}] = d[15:8];
      model[{a[5:0], 1'b1}] = d[7:0];
    end else model[a] = d[7:0];
  endtask

  task automatic sbit(input logic v);
    @(negedge clk) sk = 1'b0; di = v;
    @(negedge clk) sk = 1'b1;
    @(negedge clk);
  endtask

  task automatic head(input logic o, input int zeros, input logic [1:0] op, input logic [6:0] a);
    @(negedge clk) org = o; cs = 1'b1; sk = 1'b0;
    for (int z = 0; z < zeros; z++) sbit(1'b0);
    sbit(1'b1); sbit(op[1]); sbit(op[0]);
    for (int i = (o ? 5 : 6); i >= 0; i--) sbit(a[i]);
  endtask

  task automatic endf;
    @(negedge clk) sk = 1'b0; cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle;
    repeat (PROG + 6) @(negedge clk);
  endtask

  task automatic send_data(input logic o, input logic [15:0] d);
    for (int i = (o ? 15 : 7); i >= 0; i--) sbit(d[i]);
  endtask

  function automatic logic [6:0] spec_addr(input logic o, input logic [1:0] sub);
    return o ? {1'b0, sub, 4'b0000} : {sub, 5'b00000};
  endfunction

  task automatic do_read(input logic o, input logic [6:0] a, input int zeros, input string req);
    logic [15:0] v;
    v = '0;
    head(o, zeros, 2'b10, a);
    chk({req, " dummy"}, {14'b0, do_oe, do_o}, 16'h0002);
    for (int i = 0; i < (o ? 16 : 8); i++) begin
      sbit(1'b0);
      v = {v[14:0], do_o};
    end
    chk(req, v, exp_word(o, o ? {1'b0, a[5:0]} : a));
    endf;
  endtask

  task automatic do_write(input logic o, input logic [6:0] a, input logic [15:0] d);
    head(o, 0, 2'b01, a); send_data(o, d); endf;
    if (wel_m) model_put(o, a, o ? d : {8'h00, d[7:0]});
    settle;
  endtask

  task automatic do_erase(input logic o, input logic [6:0] a);
    head(o, 0, 2'b11, a); endf;
    if (wel_m) model_put(o, a, 16'hFFFF);
    settle;
  endtask

  task automatic do_eral(input logic o);
    head(o, 0, 2'b00, spec_addr(o, 2'b10)); endf;
    if (wel_m) for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    settle;
  endtask

  task automatic do_wral(input logic o, input logic [15:0] d);
    head(o, 0, 2'b00, spec_addr(o, 2'b01)); send_data(o, d); endf;
    if (wel_m) for (int i = 0; i < 128; i++)
      model[i] = o ? ((i % 2) == 1 ? d[7:0] : d[15:8]) : d[7:0];
    settle;
  endtask

  task automatic do_en(input logic o, input logic en);
    head(o, 0, 2'b00, spec_addr(o, en ? 2'b11 : 2'b00)); endf;
    wel_m = en;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1'b1, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [6:0]  a;
    logic [15:0] d;
    logic        o;
    runs = 0; fails = 0; wel_m = 1'b0;
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0; org = 1'b0;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12 / R9: idle after reset
    chk("R9 oe with cs low", {15'b0, do_oe}, 16'h0000);
    cs = 1'b1; repeat (3) @(negedge clk);
    chk("R12 oe after reset", {15'b0, do_oe}, 16'h0000);
    cs = 1'b0; repeat (2) @(negedge clk);

    // R7: latch clear after reset, write starts no cycle
    head(1'b0, 0, 2'b01, 7'd5); send_data(1'b0, 16'h003C); endf;
    @(negedge clk) cs = 1'b1; repeat (3) @(negedge clk);
    chk("R7 no cycle without enable", {15'b0, do_oe}, 16'h0000);
    cs = 1'b0; repeat (2) @(negedge clk);

    // R6: erase-all
    do_en(1'b0, 1'b1);
    do_eral(1'b1);
    do_read(1'b0, 7'd0, 0, "R6 erase-all low");
    do_read(1'b0, 7'd127, 0, "R6 erase-all high");
    do_read(1'b0, 7'd5, 0, "R7 write before enable");

    // R8 / R11: status and ignored frame while busy
    head(1'b1, 0, 2'b01, 7'd3); send_data(1'b1, 16'hA55A); endf;
    model_put(1'b1, 7'd3, 16'hA55A);
    @(negedge clk) cs = 1'b1; repeat (2) @(negedge clk);
    chk("R8 busy status", {14'b0, do_oe, do_o}, 16'h0002);
    head(1'b0, 0, 2'b01, 7'd20); send_data(1'b0, 16'h0077);
    chk("R11 still busy after ignored frame", {14'b0, do_oe, do_o}, 16'h0002);
    endf;
    @(negedge clk) cs = 1'b1; repeat (PROG) @(negedge clk);
    chk("R8 ready status", {14'b0, do_oe, do_o}, 16'h0003);
    endf;
    do_read(1'b1, 7'd3, 0, "R4 x16 write");
    do_read(1'b0, 7'd6, 0, "R3 upper byte of word 3");
    do_read(1'b0, 7'd7, 0, "R3 lower byte of word 3");
    do_read(1'b0, 7'd20, 0, "R11 frame while busy");

    // R1: leading zeros
    do_read(1'b1, 7'd3, 3, "R1 leading zeros");

    // R10: abort mid-frame
    head(1'b0, 0, 2'b01, 7'd9); sbit(1'b0); sbit(1'b1); sbit(1'b0); sbit(1'b1); endf;
    @(negedge clk) cs = 1'b1; repeat (3) @(negedge clk);
    chk("R10 no cycle after abort", {15'b0, do_oe}, 16'h0000);
    cs = 1'b0; repeat (2) @(negedge clk);
    do_read(1'b0, 7'd9, 0, "R10 memory unchanged");

    // R4 / R5: write then erase, x8
    do_write(1'b0, 7'd10, 16'h0012);
    do_read(1'b0, 7'd10, 0, "R4 x8 write");
    do_erase(1'b0, 7'd10);
    do_read(1'b0, 7'd10, 0, "R5 erase");

    // R6: write-all
    do_wral(1'b1, 16'hBEEF);
    do_read(1'b1, 7'd0, 0, "R6 write-all first");
    do_read(1'b1, 7'd63, 0, "R6 write-all last");
    do_read(1'b0, 7'd33, 0, "R6 write-all byte view");

    // R7: disable blocks programming
    do_en(1'b0, 1'b0);
    do_write(1'b0, 7'd11, 16'h0099);
    do_read(1'b0, 7'd11, 0, "R7 write after disable");
    do_erase(1'b1, 7'd2);
    do_read(1'b1, 7'd2, 0, "R7 erase after disable");

    // random mix
    for (int n = 0; n < 40; n++) begin
      o = 1'($urandom_range(0, 1));
      a = 7'($urandom_range(0, 127));
      d = 16'($urandom_range(0, 65535));
      case ($urandom_range(0, 9))
        0:       do_en(o, 1'($urandom_range(0, 3) != 0));
        1, 2, 3: do_write(o, a, d);
        4:       do_erase(o, a);
        5:       if ($urandom_range(0, 3) == 0) do_wral(o, d);
        default: do_read(o, a, 0, "R2 random read");
      endcase
    end
    do_read(1'b0, 7'd44, 0, "R2 final read x8");
    do_read(1'b1, 7'd21, 0, "R2 final read x16");

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule